// File: doc/BRIEF.md
# SDRAM Data Lane Latency and Byte-Mask Pipeline

This block models the device-side data timing of one 16-bit SDRAM data lane with two byte masks. It takes already-decoded commands (read, write, precharge, burst stop), the mode fields for read latency, burst length and single-location writes, the per-byte mask inputs and the word the array supplies for each read beat. From these it produces the registered read data bus, a registered output enable per byte and a same-cycle write strobe per byte.

Read beats are produced one per clock for the programmed burst length. A full-page burst runs until another command ends it. Each beat is carried through a short register pipeline whose tap is chosen by the latency code. Read masks act two clocks after they are sampled, whatever the latency. Write masks act in the cycle they are sampled. A mode bit can cut every write to a single beat while reads keep their burst length. A new command is accepted on any clock and takes over from the burst in progress.

Top module: `sdr_dq_lane`

## Requirements
- R1: Let a read command be sampled at rising edge n with latency m. Latency code 3'b010 gives m=2 and code 3'b011 gives m=3. The data of burst beat k is loaded into dq_out/dq_oe at edge n+k+m-1, so it is valid at edge n+k+m. That data equals the rd_data value present at edge n+k.
- R2: Every other latency code behaves as m=3. lat_err reads 1 after the next edge while such a code is applied, and reads 0 after the next edge once 3'b010 or 3'b011 is applied.
- R3: On reads, dqm[b] sampled high at edge j clears dq_oe[b] for the data valid at edge j+2. Byte b is dq_out[8b+7:8b]. dqm[b] sampled low lets that byte drive when a beat is due.
- R4: On writes, wr_strobe[b] is high in a write-beat cycle only when dqm[b] is low in that same cycle. A high mask suppresses the strobe for that byte.
- R5: Burst length code bl_code gives 3'b000 = 1, 3'b001 = 2, 3'b010 = 4, 3'b011 = 8 beats. Code 3'b111 selects full page, which runs until another command arrives. Any other code gives 1 beat.
- R6: With wr_single = 1 every write gives exactly one beat, full page included. Reads keep the programmed burst length.
- R7: A precharge or burst stop sampled at edge p ends a running burst. The last read beat is the one issued at edge p-1. dq_oe returns to zero at edge p+m-1, so the lane is released by edge p+m.
- R8: A command may be issued on every clock. A new read or write ends the burst in progress and starts its own burst at that edge. At most one command input is high in a cycle.
- R9: While reset is applied, dq_oe, wr_strobe, dq_out and lat_err are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_cmd | input | 1 | Decoded read command |
| wr_cmd | input | 1 | Decoded write command |
| pre_cmd | input | 1 | Decoded precharge (ends a burst) |
| term_cmd | input | 1 | Decoded burst stop |
| lat_code | input | 3 | Read latency mode field |
| bl_code | input | 3 | Burst length mode field |
| wr_single | input | 1 | Writes limited to one beat when high |
| dqm | input | 2 | Byte mask, bit b covers byte b |
| rd_data | input | 16 | Array word for the current read beat |
| dq_out | output | 16 | Registered read data bus |
| dq_oe | output | 2 | Registered output enable per byte |
| wr_strobe | output | 2 | Same-cycle write enable per byte |
| lat_err | output | 1 | Reserved latency code applied |

## Verification
The hardest case to reach is the hand-off between bursts. A read can be cut off by another read one clock later, then by a write, and that write by a further read. The read pipeline may still be draining while write strobes fire. The bench builds such sequences from per-edge command tables. It computes the expected beat edges and mask effects from the requirements, and checks the cycles that straddle each hand-off. The latency codes, burst codes, single-write mode and full-page bursts ended by precharge or burst stop are swept in full.

// File: rtl/sdr_lane_pkg.sv
package sdr_lane_pkg;

  typedef logic [2:0] mode_code_t;

  localparam mode_code_t LAT_TWO   = 3'b010;
  localparam mode_code_t LAT_THREE = 3'b011;
  localparam mode_code_t BL_PAGE   = 3'b111;

  // Beats that follow the first one for a fixed-length burst code.
  function automatic int burst_extra(input mode_code_t code);
    case (code)
      3'b001:  return 1;
      3'b010:  return 3;
      3'b011:  return 7;
      default: return 0;
    endcase
  endfunction

  function automatic int lat_cycles(input mode_code_t code);
    return (code == LAT_TWO) ? 2 : 3;
  endfunction

  function automatic logic lat_reserved(input mode_code_t code);
    return !((code == LAT_TWO) || (code == LAT_THREE));
  endfunction

endpackage

// File: rtl/sdr_beat_gen.sv
module sdr_beat_gen
  import sdr_lane_pkg::*;
#(
  parameter int MAX_BURST = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       kill,
  input  mode_code_t len_code,
  input  logic       single,
  output logic       beat
);

  localparam int CW = $clog2(MAX_BURST);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          page_q, page_d;
  logic          active;

  always_comb begin
    active = (cnt_q != '0) || page_q;
    beat   = start || (active && !kill);
    cnt_d  = cnt_q;
    page_d = page_q;
    if (start) begin
      cnt_d  = single ? '0 : CW'(burst_extra(len_code));
      page_d = !single && (len_code == BL_PAGE);
    end else if (kill) begin
      cnt_d  = '0;
      page_d = 1'b0;
    end else if (active && !page_q) begin
      cnt_d  = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      page_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      page_q <= page_d;
    end
  end

  // R7: a terminating command leaves no continuation beat
  a_r7_kill_ends_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (kill && !start) |=> (beat == start));

  // R6: single-location access never continues past its first beat
  a_r6_single_one_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (start && single) |=> (beat == start));

endmodule

// File: rtl/sdr_rd_pipe.sv
module sdr_rd_pipe #(
  parameter int DW     = 16,
  parameter int MAX_CL = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         beat,
  input  logic [DW-1:0]                rd_data,
  input  logic [DW/8-1:0]              dqm,
  input  logic [$clog2(MAX_CL+1)-1:0]  cl_sel,
  output logic [DW-1:0]                dq_out,
  output logic [DW/8-1:0]              dq_oe
);

  localparam int NB   = DW / 8;
  localparam int NSTG = MAX_CL - 1;
  localparam int CLW  = $clog2(MAX_CL + 1);

  logic [NSTG-1:0] st_v;
  logic [DW-1:0]   st_d [NSTG];
  logic [NB-1:0]   dqm_q;
  logic            sel_v;
  logic [DW-1:0]   sel_d;
  logic [NB-1:0]   oe_d;

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    logic          in_v;
    logic [DW-1:0] in_d;
    if (g == 0) begin : g_head
      assign in_v = beat;
      assign in_d = rd_data;
    end else begin : g_link
      assign in_v = st_v[g-1];
      assign in_d = st_d[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_v[g] <= 1'b0;
      else        st_v[g] <= in_v;
    end

    always_ff @(posedge clk) begin
      if (in_v) st_d[g] <= in_d;
    end
  end

  always_comb begin
    sel_v = 1'b0;
    sel_d = '0;
    for (int i = 0; i < NSTG; i++) begin
      if (cl_sel == CLW'(i + 2)) begin
        sel_v = st_v[i];
        sel_d = st_d[i];
      end
    end
    oe_d = {NB{sel_v}} & ~dqm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dqm_q  <= '1;
      dq_oe  <= '0;
      dq_out <= '0;
    end else begin
      dqm_q <= dqm;
      dq_oe <= oe_d;
      if (sel_v) dq_out <= sel_d;
    end
  end

  // R1: the lane drives only for a beat issued m-1 edges before the load
  a_r1_oe_follows_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (|dq_oe) |-> ($past(beat, 2) || $past(beat, 3)));

  // R3: a byte masked two edges earlier never drives
  a_r3_read_mask_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe & $past(dqm, 2)) == '0);

endmodule

// File: rtl/sdr_dq_lane.sv
module sdr_dq_lane
  import sdr_lane_pkg::*;
#(
  parameter int DW        = 16,
  parameter int MAX_BURST = 8,
  parameter int MAX_CL    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_cmd,
  input  logic              wr_cmd,
  input  logic              pre_cmd,
  input  logic              term_cmd,
  input  logic [2:0]        lat_code,
  input  logic [2:0]        bl_code,
  input  logic              wr_single,
  input  logic [DW/8-1:0]   dqm,
  input  logic [DW-1:0]     rd_data,
  output logic [DW-1:0]     dq_out,
  output logic [DW/8-1:0]   dq_oe,
  output logic [DW/8-1:0]   wr_strobe,
  output logic              lat_err
);

  localparam int NB  = DW / 8;
  localparam int CLW = $clog2(MAX_CL + 1);

  logic [1:0]     rst_sync;
  logic           rst_l;
  logic [CLW-1:0] cl_sel;
  logic           lat_err_d;
  logic           rd_beat, wr_beat;
  logic           rd_kill, wr_kill;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_l = rst_sync[1];

  always_comb begin
    cl_sel    = CLW'(lat_cycles(lat_code));
    lat_err_d = lat_reserved(lat_code);
    rd_kill   = wr_cmd || pre_cmd || term_cmd;
    wr_kill   = rd_cmd || pre_cmd || term_cmd;
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) lat_err <= 1'b0;
    else        lat_err <= lat_err_d;
  end

  sdr_beat_gen #(.MAX_BURST(MAX_BURST)) u_rd_beats (
    .clk      (clk),
    .rst_n    (rst_l),
    .start    (rd_cmd),
    .kill     (rd_kill),
    .len_code (bl_code),
    .single   (1'b0),
    .beat     (rd_beat)
  );

  sdr_beat_gen #(.MAX_BURST(MAX_BURST)) u_wr_beats (
    .clk      (clk),
    .rst_n    (rst_l),
    .start    (wr_cmd),
    .kill     (wr_kill),
    .len_code (bl_code),
    .single   (wr_single),
    .beat     (wr_beat)
  );

  sdr_rd_pipe #(.DW(DW), .MAX_CL(MAX_CL)) u_rd_pipe (
    .clk     (clk),
    .rst_n   (rst_l),
    .beat    (rd_beat),
    .rd_data (rd_data),
    .dqm     (dqm),
    .cl_sel  (cl_sel),
    .dq_out  (dq_out),
    .dq_oe   (dq_oe)
  );

  assign wr_strobe = {NB{wr_beat && rst_l}} & ~dqm;

  // R8: decoded commands arrive one at a time
  a_r8_one_command: assert property (@(posedge clk) disable iff (!rst_l)
    $countones({rd_cmd, wr_cmd, pre_cmd, term_cmd}) <= 1);

  // R4: no write strobe on a byte whose mask is high in the same cycle
  a_r4_write_mask_now: assert property (@(posedge clk) disable iff (!rst_l)
    (wr_strobe & dqm) == '0);

endmodule

// File: tb/sdr_dq_lane_tb.sv
`timescale 1ns/1ps
module sdr_dq_lane_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_cmd, wr_cmd, pre_cmd, term_cmd;
  logic [2:0]  lat_code, bl_code;
  logic        wr_single;
  logic [1:0]  dqm;
  logic [15:0] rd_data;
  logic [15:0] dq_out;
  logic [1:0]  dq_oe, wr_strobe;
  logic        lat_err;

  always #2 clk = ~clk;

  sdr_dq_lane u_dut (
    .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd),
    .pre_cmd(pre_cmd), .term_cmd(term_cmd), .lat_code(lat_code),
    .bl_code(bl_code), .wr_single(wr_single), .dqm(dqm),
    .rd_data(rd_data), .dq_out(dq_out), .dq_oe(dq_oe),
    .wr_strobe(wr_strobe), .lat_err(lat_err)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;
  int E     = 0;
  int psel  = 0;

  bit         a_rd [0:2047];
  bit         a_wr [0:2047];
  bit         a_pre[0:2047];
  bit         a_trm[0:2047];
  bit         xr   [0:2047];
  bit         xw   [0:2047];
  logic [1:0] a_dqm[0:2047];

  function automatic logic [15:0] rdd(input int e);
    return 16'(e * 291) ^ 16'hA5C3;
  endfunction

  function automatic logic [1:0] dqpat(input int e, input int sel);
    if (sel == 0) return 2'b00;
    return {(e % 3) == 0, (e % 5) == 1};
  endfunction

  function automatic int blen(input logic [2:0] c);
    case (c)
      3'b001:  return 2;
      3'b010:  return 4;
      3'b011:  return 8;
      default: return 1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s edge=%0d actual=%h expected=%h", req, E, act, exp);
    end
  endtask

  // m: expected latency for this window
  task automatic run(input int n, input int m, input bit lerr);
    for (int i = 0; i < n; i++) begin
      logic [1:0] exp_oe;
      int src;
      a_dqm[E] = dqpat(E, psel);
      rd_cmd   = a_rd[E];
      wr_cmd   = a_wr[E];
      pre_cmd  = a_pre[E];
      term_cmd = a_trm[E];
      dqm      = a_dqm[E];
      rd_data  = rdd(E);
      #1;
      // R4 R6: same-cycle write strobe
      chk(wr_strobe == (xw[E] ? ~a_dqm[E] : 2'b00), "R4/R6 wr_strobe",
          32'(wr_strobe), 32'(xw[E] ? ~a_dqm[E] : 2'b00));
      @(posedge clk);
      @(negedge clk);
      src = E - m + 1;
      exp_oe = (src >= 0 && xr[src]) ? ~a_dqm[E-1] : 2'b00;
      // R1 R3 R7: registered enable after latency with delayed mask
      chk(dq_oe == exp_oe, "R1/R3/R7 dq_oe", 32'(dq_oe), 32'(exp_oe));
      if (src >= 0 && xr[src])
        chk(dq_out == rdd(src), "R1/R5 dq_out", 32'(dq_out), 32'(rdd(src)));
      // R2: reserved latency flag
      chk(lat_err == lerr, "R2 lat_err", 32'(lat_err), 32'(lerr));
      E++;
    end
  endtask

  task automatic idle_cmds();
    rd_cmd = 0; wr_cmd = 0; pre_cmd = 0; term_cmd = 0;
  endtask

  initial begin
    logic [2:0] lcodes [4];
    logic [2:0] bcodes [5];
    int S, m, L;
    lcodes = '{3'b010, 3'b011, 3'b000, 3'b101};
    bcodes = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b100};
    rst_n = 0;
    idle_cmds();
    lat_code = 3'b010; bl_code = 3'b000; wr_single = 0;
    dqm = 2'b00; rd_data = 16'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk(dq_oe == 2'b00, "R9 dq_oe reset", 32'(dq_oe), 0);
    chk(wr_strobe == 2'b00, "R9 wr_strobe reset", 32'(wr_strobe), 0);
    chk(dq_out == 16'h0, "R9 dq_out reset", 32'(dq_out), 0);
    chk(lat_err == 1'b0, "R9 lat_err reset", 32'(lat_err), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 R2 R3 R5: read sweep over latency and burst codes
    for (int li = 0; li < 4; li++) begin
      for (int bi = 0; bi < 5; bi++) begin
        lat_code  = lcodes[li];
        bl_code   = bcodes[bi];
        wr_single = li[0];
        psel      = bi % 2;
        m = (li == 0) ? 2 : 3;
        L = blen(bcodes[bi]);
        S = E + 1;
        a_rd[S] = 1;
        for (int k = 0; k < L; k++) xr[S+k] = 1;
        run(L + 8, m, li >= 2);
      end
    end

    // R4 R5 R6: write sweep, reads idle
    lat_code = 3'b010;
    psel = 1;
    for (int s = 0; s < 2; s++) begin
      for (int bi = 0; bi < 5; bi++) begin
        wr_single = s[0];
        bl_code   = bcodes[bi];
        L = s ? 1 : blen(bcodes[bi]);
        S = E + 1;
        a_wr[S] = 1;
        for (int k = 0; k < L; k++) xw[S+k] = 1;
        run(blen(bcodes[bi]) + 4, 2, 0);
      end
    end

    // R5 R7: full-page reads ended by precharge or burst stop
    bl_code = 3'b111;
    wr_single = 0;
    for (int li = 0; li < 2; li++) begin
      for (int kt = 0; kt < 2; kt++) begin
        lat_code = lcodes[li];
        psel = kt;
        m = li + 2;
        S = E + 1;
        a_rd[S] = 1;
        if (kt == 0) a_pre[S+6] = 1;
        else         a_trm[S+6] = 1;
        for (int k = 0; k < 6; k++) xr[S+k] = 1;
        run(16, m, 0);
      end
    end

    // R5 R7: full-page write ended by burst stop
    lat_code = 3'b011;
    S = E + 1;
    a_wr[S] = 1; a_trm[S+5] = 1;
    for (int k = 0; k < 5; k++) xw[S+k] = 1;
    run(10, 3, 0);

    // R6: full-page write in single mode gives one beat
    wr_single = 1;
    S = E + 1;
    a_wr[S] = 1; xw[S] = 1;
    run(8, 3, 0);

    // R8: back-to-back reads, write takeover, read takeover
    wr_single = 0;
    bl_code = 3'b010;
    psel = 0;
    S = E + 1;
    a_rd[S] = 1; a_rd[S+1] = 1; a_rd[S+2] = 1;
    a_wr[S+3] = 1; a_rd[S+5] = 1;
    xr[S] = 1; xr[S+1] = 1; xr[S+2] = 1;
    xw[S+3] = 1; xw[S+4] = 1;
    for (int k = 5; k < 9; k++) xr[S+k] = 1;
    run(16, 3, 0);

    // R2: flag clears after a valid code follows a reserved one
    lat_code = 3'b110;
    run(3, 3, 1);
    lat_code = 3'b011;
    run(3, 3, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule